// File: doc/BRIEF.md
# Nested-Priority Cascade-Slave Interrupt Controller

This block is an eight-level priority interrupt controller that sits below an external master controller in a cascade. It keeps each request line's rising edge in a request register and keeps the levels being serviced in an in-service register. It raises a request toward the master while a pending level outranks everything in service. When an acknowledge arrives with the slave-select input high, it hands back an 8-bit vector. The upper five bits of that vector come from a programmable base register. The lower three bits give the number of the winning level.

Software ends service of a level by writing that level's number to the specific end-of-interrupt register. This is the only way an in-service bit clears. While a level is in service, only levels of equal or higher priority can be acknowledged, so service can nest. An acknowledge seen with slave-select low is meant for another device. It is passed one cycle later to the acknowledge output, which can drive a downstream controller.

The vector leaves the block as a one-cycle valid strobe with no ready input. The acknowledge is itself the consumer's request, so there is no back-pressure. The consumer must capture `vec_data` in the cycle `vec_valid` is high.

Top module: `nest_irq_slave`

## Requirements
- R1: After reset, `int_req`, `vec_valid` and `ack_out` are low, no request or in-service bit is set, and the vector base is zero.
- R2: A rising edge on `irq_in[i]` latches request i. A line held high after its request was acknowledged does not request again until it falls and rises.
- R3: Level 0 has the highest priority and level 7 the lowest. Among eligible pending requests, the lowest-numbered level wins.
- R4: When `ack_in` and `sel_in` are high at a clock edge and a level is eligible, `vec_valid` is high for exactly the following cycle. At the same edge the winner's request bit clears and its in-service bit sets.
- R5: A write with `wr_addr` = 0x20 loads `wr_data[7:3]` into the vector base and ignores `wr_data[2:0]`. `vec_data` = {base, winning level[2:0]}.
- R6: While level k is the highest-priority level in service, levels numbered above k are never acknowledged, and an acknowledge with only such levels pending gives no vector.
- R7: `int_req` is high exactly when some pending level has a strictly smaller number than every in-service level (any pending level when nothing is in service).
- R8: A write with `wr_addr` = 0x22 clears the in-service bit of level `wr_data[2:0]` only.
- R9: An acknowledge with `sel_in` low gives no vector and changes no request or in-service bit.
- R10: `ack_out` is high in the cycle after a clock edge at which `ack_in` is high and `sel_in` is low, and is low otherwise.
- R11: A level pending while the same level is in service is eligible, and is acknowledged even though `int_req` stays low.
- R12: Writes to any address other than 0x20 and 0x22 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines, edge sensitive, index is level |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write offset |
| wr_data | input | 8 | Register write data |
| sel_in | input | 1 | Slave select, decoded cascade address |
| ack_in | input | 1 | Acknowledge from the master |
| int_req | output | 1 | Request toward the master |
| vec_valid | output | 1 | One-cycle strobe for vec_data |
| vec_data | output | 8 | Vector: base in [7:3], level in [2:0] |
| ack_out | output | 1 | Forwarded acknowledge for a downstream controller |

## Verification
The assertions check several things on every cycle. A new edge always ends up in the request register. A vector only follows a selected acknowledge, and the level named in any vector is then in service. The grant stays one-hot. An end-of-interrupt clears its named level unless a grant of that level lands in the same cycle. Other properties can only be shown through the bench's scenarios. These are the priority order among simultaneous requests, the blocking of lower levels during nested service, and the equal-level grant while `int_req` is low. The scenarios also show that an end-of-interrupt naming a lower level leaves the higher one in service, and that a held line or a stray write has no effect.

// File: rtl/nis_pkg.sv
package nis_pkg;
  localparam int NIS_LVLS = 8;
  localparam int NIS_LW   = $clog2(NIS_LVLS);
  typedef logic [NIS_LW-1:0] lvl_t;
  typedef struct packed {
    logic hit;
    lvl_t lvl;
  } grant_t;
endpackage

// File: rtl/nis_req_latch.sv
module nis_req_latch #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] irq_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] req_o
);
  logic [N-1:0] prev_q, req_q, rise;

  assign rise  = irq_i & ~prev_q;
  assign req_o = req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q <= '0;
      req_q  <= '0;
    end else begin
      prev_q <= irq_i;
      req_q  <= (req_q & ~clr_i) | rise;
    end
  end

  assert_edge_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|rise) |=> ((req_q & $past(rise)) == $past(rise)));
endmodule

// File: rtl/nis_prio.sv
module nis_prio
  import nis_pkg::*;
#(
  parameter int N = NIS_LVLS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] isr_i,
  output grant_t       win_o,
  output logic [N-1:0] win_oh_o,
  output logic         hp_pend_o
);
  logic [N-1:0] elig, strict, cand;

  assign elig[0] = 1'b1;
  for (genvar i = 1; i < N; i++) begin : g_elig
    assign elig[i] = elig[i-1] & ~isr_i[i-1];
  end
  for (genvar i = 0; i < N; i++) begin : g_strict
    assign strict[i] = elig[i] & ~isr_i[i];
  end

  assign cand      = req_i & elig;
  assign hp_pend_o = |(req_i & strict);

  always_comb begin
    win_o    = '0;
    win_oh_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) begin
        win_o.hit = 1'b1;
        win_o.lvl = lvl_t'(i);
        win_oh_o  = '0;
        win_oh_o[i] = 1'b1;
      end
    end
  end

  assert_grant_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_oh_o));
  assert_hp_has_winner_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hp_pend_o |-> win_o.hit);
endmodule

// File: rtl/nis_isr.sv
module nis_isr
  import nis_pkg::*;
#(
  parameter int N = NIS_LVLS
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  lvl_t         set_lvl,
  input  logic         eoi_en,
  input  lvl_t         eoi_lvl,
  output logic [N-1:0] isr_o
);
  logic [N-1:0] isr_q;
  assign isr_o = isr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (set_en && set_lvl == lvl_t'(i)) isr_q[i] <= 1'b1;
        else if (eoi_en && eoi_lvl == lvl_t'(i)) isr_q[i] <= 1'b0;
      end
    end
  end

  assert_eoi_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_en && !(set_en && set_lvl == eoi_lvl)) |=> !isr_q[$past(eoi_lvl)]);
endmodule

// File: rtl/nest_irq_slave.sv
module nest_irq_slave
  import nis_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                VEC_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h20,
  parameter logic [ADDR_W-1:0] EOI_ADDR  = 'h22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NIS_LVLS-1:0] irq_in,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [VEC_W-1:0]    wr_data,
  input  logic                sel_in,
  input  logic                ack_in,
  output logic                int_req,
  output logic                vec_valid,
  output logic [VEC_W-1:0]    vec_data,
  output logic                ack_out
);
  localparam int BASE_W = VEC_W - NIS_LW;

  logic [NIS_LVLS-1:0] req_q, isr_q, win_oh, clr;
  grant_t              win;
  logic                hp_pend, ack_go, eoi_en, base_we;
  logic [BASE_W-1:0]   base_q;
  logic                vv_q, ao_q;
  logic [VEC_W-1:0]    vd_q;

  assign ack_go  = ack_in & sel_in & win.hit;
  assign clr     = ack_go ? win_oh : '0;
  assign eoi_en  = wr_en && (wr_addr == EOI_ADDR);
  assign base_we = wr_en && (wr_addr == BASE_ADDR);

  nis_req_latch #(.N(NIS_LVLS)) u_req (
    .clk(clk), .rst_n(rst_n), .irq_i(irq_in), .clr_i(clr), .req_o(req_q));

  nis_prio #(.N(NIS_LVLS)) u_prio (
    .clk(clk), .rst_n(rst_n), .req_i(req_q), .isr_i(isr_q),
    .win_o(win), .win_oh_o(win_oh), .hp_pend_o(hp_pend));

  nis_isr #(.N(NIS_LVLS)) u_isr (
    .clk(clk), .rst_n(rst_n), .set_en(ack_go), .set_lvl(win.lvl),
    .eoi_en(eoi_en), .eoi_lvl(wr_data[NIS_LW-1:0]), .isr_o(isr_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      vv_q   <= 1'b0;
      vd_q   <= '0;
      ao_q   <= 1'b0;
    end else begin
      if (base_we) base_q <= wr_data[VEC_W-1:NIS_LW];
      vv_q <= ack_go;
      if (ack_go) vd_q <= {base_q, win.lvl};
      ao_q <= ack_in & ~sel_in;
    end
  end

  assign int_req   = hp_pend;
  assign vec_valid = vv_q;
  assign vec_data  = vd_q;
  assign ack_out   = ao_q;

  assert_vec_needs_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack_in && sel_in) |=> !vec_valid);
  assert_vec_level_in_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> isr_q[vec_data[NIS_LW-1:0]]);
  assert_no_req_no_int_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q == '0) |-> !int_req);
  assert_ackout_excl_vec_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ack_out |-> !vec_valid);
endmodule

// File: tb/test_nest_irq_slave.sv
module test_nest_irq_slave;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [7:0] irq_in = '0, wr_addr = '0, wr_data = '0, vec_data;
  logic       wr_en = 1'b0, sel_in = 1'b0, ack_in = 1'b0;
  logic       int_req, vec_valid, ack_out;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  nest_irq_slave i_nest_irq_slave (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .sel_in(sel_in), .ack_in(ack_in), .int_req(int_req),
    .vec_valid(vec_valid), .vec_data(vec_data), .ack_out(ack_out));

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] m);
    @(negedge clk); irq_in = m;
    @(negedge clk); irq_in = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ack(input logic s, output logic v, output logic [7:0] d, output logic ao);
    @(negedge clk); ack_in = 1'b1; sel_in = s;
    @(negedge clk); ack_in = 1'b0; sel_in = 1'b0;
    v = vec_valid; d = vec_data; ao = ack_out;
  endtask

  task automatic expect_vec(input string tag, input logic [7:0] exp);
    logic v, ao; logic [7:0] d;
    ack(1'b1, v, d, ao);
    check(v == 1'b1, {tag, " valid"}, v, 1);
    check(d == exp, {tag, " data"}, d, exp);
  endtask

  task automatic t_reset();
    logic v, ao; logic [7:0] d;
    check(!int_req && !vec_valid && !ack_out, "R1 outputs", {int_req, vec_valid, ack_out}, 0);
    ack(1'b1, v, d, ao);
    check(!v, "R1 no pending", v, 0);
  endtask

  task automatic t_base_and_eoi();
    pulse(8'h01);
    expect_vec("R1 base zero", 8'h00);
    wr(8'h22, 8'h00);
    wr(8'h20, 8'hAF);
    pulse(8'h20);
    check(int_req, "R7 pending raises", int_req, 1);
    expect_vec("R5 R4 vector", 8'hAD);
    check(!int_req, "R4 req cleared", int_req, 0);
    @(negedge clk);
    check(!vec_valid, "R4 single cycle", vec_valid, 0);
    wr(8'h22, 8'h05);
    pulse(8'h40);
    check(int_req, "R8 eoi reopens", int_req, 1);
    expect_vec("R8 next", 8'hAE);
    wr(8'h22, 8'h06);
  endtask

  task automatic t_priority_nest();
    logic v, ao; logic [7:0] d;
    pulse(8'h94);
    expect_vec("R3 lowest wins", 8'hAA);
    check(!int_req, "R7 lower blocked", int_req, 0);
    ack(1'b1, v, d, ao);
    check(!v, "R6 no lower grant", v, 0);
    pulse(8'h02);
    check(int_req, "R7 higher raises", int_req, 1);
    expect_vec("R6 nested", 8'hA9);
    wr(8'h22, 8'h01);
    check(!int_req, "R6 still blocked", int_req, 0);
    wr(8'h22, 8'h02);
    check(int_req, "R7 after eoi", int_req, 1);
    expect_vec("R3 next 4", 8'hAC);
    wr(8'h22, 8'h04);
    expect_vec("R3 next 7", 8'hAF);
    wr(8'h22, 8'h07);
  endtask

  task automatic t_specific_eoi();
    pulse(8'h08);
    expect_vec("R8 set3", 8'hAB);
    pulse(8'h02);
    expect_vec("R8 set1", 8'hA9);
    wr(8'h22, 8'h03);
    pulse(8'h04);
    check(!int_req, "R8 level1 kept", int_req, 0);
    wr(8'h22, 8'h01);
    check(int_req, "R8 now free", int_req, 1);
    expect_vec("R8 grant2", 8'hAA);
    wr(8'h22, 8'h02);
    pulse(8'h20);
    check(int_req, "R8 three cleared", int_req, 1);
    expect_vec("R8 grant5", 8'hAD);
    wr(8'h22, 8'h05);
  endtask

  task automatic t_no_select();
    logic v, ao; logic [7:0] d;
    pulse(8'h01);
    ack(1'b0, v, d, ao);
    check(!v, "R9 no vector", v, 0);
    check(ao, "R10 forwarded", ao, 1);
    check(int_req, "R9 state kept", int_req, 1);
    ack(1'b1, v, d, ao);
    check(v && d == 8'hA8, "R9 later grant", d, 8'hA8);
    check(!ao, "R10 quiet on select", ao, 0);
    wr(8'h22, 8'h00);
  endtask

  task automatic t_equal_level();
    pulse(8'h08);
    expect_vec("R11 first", 8'hAB);
    pulse(8'h08);
    check(!int_req, "R11 int low", int_req, 0);
    expect_vec("R11 equal grant", 8'hAB);
    wr(8'h22, 8'h03);
  endtask

  task automatic t_held_and_stray();
    logic v, ao; logic [7:0] d;
    @(negedge clk); irq_in = 8'h40;
    @(negedge clk);
    expect_vec("R2 held first", 8'hAE);
    wr(8'h22, 8'h06);
    check(!int_req, "R2 held no repeat", int_req, 0);
    ack(1'b1, v, d, ao);
    check(!v, "R2 held no vector", v, 0);
    @(negedge clk); irq_in = '0;
    wr(8'h24, 8'hFF);
    wr(8'h21, 8'h00);
    pulse(8'h01);
    expect_vec("R12 base kept", 8'hA8);
    wr(8'h22, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_base_and_eoi();
    t_priority_nest();
    t_specific_eoi();
    t_no_select();
    t_equal_level();
    t_held_and_stray();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule